// File: doc/BRIEF.md
# Prescaled Wide Synchronous Counter

A free-running up-counter, 64 bits wide by default, that advances by one on every clock cycle. It is built from two pieces: a narrow prescaler holding the low-order bits, and a wide high-order counter with an enable. The wide counter moves only once per prescaler period. Its enable is a registered flag that is computed one cycle early from the prescaler value. Because of this, the adder in the wide section has a full prescaler period to settle, and it can be given a multicycle constraint instead of a single-cycle carry path across all 64 bits.

The output is the concatenation of the high and low sections. The high section changes on the same edge where the prescaler wraps, so every sample reads as one coherent count. A synchronous reset and a synchronous clear both load a start value, which is a parameter and is zero by default. The prescaler width is also a parameter. Widening it from two to three bits doubles the settling window of the wide section.

Top module: `prescaled_counter`

## Requirements
- R1: On every clock edge where neither `rst` nor `clr` is high, `count` becomes its previous value plus one, modulo 2^CNT_W (CNT_W = 64 by default).
- R2: `count` is formed as {high section, low section}, where the low section is the PRE_W least significant bits (default 2) and the high section is the other CNT_W-PRE_W bits (default 62).
- R3: The high section changes only on an edge where the low section wraps from all ones to zero, and it then increases by exactly one. It therefore advances once every 2^PRE_W counting cycles.
- R4: The high-section advance flag is a register loaded from a decode of the prescaler one step ahead. It is high during exactly those cycles in which the low section is all ones.
- R5: When `rst` is high at a clock edge, `count` takes INIT_VALUE (default 0) on that edge.
- R6: When `clr` is high at a clock edge, `count` takes INIT_VALUE and the advance flag is reloaded with it. A clear applied while the low section is all ones therefore causes no high-section increment, and counting resumes at INIT_VALUE+1.
- R7: The count wraps from all ones to zero with no stall or held cycle.
- R8: With PRE_W = 3, the high section advances once every 8 cycles, and the carry from the low section into bit 32 appears on the correct edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, loads INIT_VALUE |
| clr | input | 1 | Synchronous clear, active high, loads INIT_VALUE |
| count | output | CNT_W | Current count {high, low} |

## Verification
The in-RTL properties check the following on every cycle:
- the plus-one step of the whole count;
- the one-step-ahead decode of the advance flag against the live prescaler value;
- the rule that the high section either holds or steps by one, following that flag;
- loading of the start value after reset or clear.

The bench scenarios cover what only chosen stimulus can reach:
- the full 64-bit wrap, using an instance started just below it;
- a carry rippling into bit 32 with a three-bit prescaler;
- a clear landing exactly on a prescaler terminal count, followed by three cycles with no high-section movement.

// File: rtl/pscnt_pkg.sv
package pscnt_pkg;

  localparam int PSC_MAX_W = 8;

  typedef logic [PSC_MAX_W-1:0] psc_vec_t;

  function automatic psc_vec_t psc_mask(int w);
    return psc_vec_t'((9'd1 << w) - 9'd1);
  endfunction

  // low section is at its terminal count (all ones)
  function automatic logic psc_at_tc(psc_vec_t v, int w);
    return (v & psc_mask(w)) == psc_mask(w);
  endfunction

  // low section is one step before its terminal count
  function automatic logic psc_before_tc(psc_vec_t v, int w);
    psc_vec_t m;
    m = psc_mask(w);
    return (v & m) == ((m - psc_vec_t'(1)) & m);
  endfunction

endpackage

// File: rtl/pscnt_prescaler.sv
module pscnt_prescaler import pscnt_pkg::*; #(
  parameter int              PRE_W   = 2,
  parameter logic [PRE_W-1:0] INIT_LO = '0
) (
  input  logic             clk,
  input  logic             load,
  output logic [PRE_W-1:0] low_q,
  output logic             adv_q
);

  logic [PRE_W-1:0] low_nxt;
  psc_vec_t         low_ext;
  psc_vec_t         init_ext;
  logic             adv_d;

  always_comb begin
    low_ext = '0;
    low_ext[PRE_W-1:0] = low_q;
    init_ext = '0;
    init_ext[PRE_W-1:0] = INIT_LO;
  end

  assign low_nxt = low_q + PRE_W'(1);
  // decode one step ahead so the flag is registered and aligned with tc
  assign adv_d   = load ? psc_at_tc(init_ext, PRE_W) : psc_before_tc(low_ext, PRE_W);

  always_ff @(posedge clk) begin
    if (load) low_q <= INIT_LO;
    else      low_q <= low_nxt;
    adv_q <= adv_d;
  end

  // R4: registered flag tracks the terminal count of the live value
  a_r4_adv_matches_tc: assert property (@(posedge clk) disable iff (load)
    adv_q == psc_at_tc(low_ext, PRE_W))
    else $error("a_r4_adv_matches_tc");

endmodule

// File: rtl/pscnt_high.sv
module pscnt_high #(
  parameter int              HI_W    = 62,
  parameter logic [HI_W-1:0] INIT_HI = '0
) (
  input  logic            clk,
  input  logic            load,
  input  logic            adv,
  output logic [HI_W-1:0] hi_q
);

  logic [HI_W-1:0] hi_sum;

  // this adder only has to settle once per prescaler period
  assign hi_sum = hi_q + HI_W'(1);

  always_ff @(posedge clk) begin
    if (load)     hi_q <= INIT_HI;
    else if (adv) hi_q <= hi_sum;
  end

  // R3: step by exactly one when enabled
  a_r3_step_on_adv: assert property (@(posedge clk) disable iff (load)
    adv |=> (hi_q - $past(hi_q)) == HI_W'(1))
    else $error("a_r3_step_on_adv");

  // R3: hold otherwise
  a_r3_hold_without_adv: assert property (@(posedge clk) disable iff (load)
    !adv |=> $stable(hi_q))
    else $error("a_r3_hold_without_adv");

endmodule

// File: rtl/prescaled_counter.sv
module prescaled_counter #(
  parameter int               CNT_W      = 64,
  parameter int               PRE_W      = 2,
  parameter logic [CNT_W-1:0] INIT_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam int HI_W = CNT_W - PRE_W;
  localparam logic [PRE_W-1:0] INIT_LO = INIT_VALUE[PRE_W-1:0];
  localparam logic [HI_W-1:0]  INIT_HI = INIT_VALUE[CNT_W-1:PRE_W];

  logic             load;
  logic             hi_adv;
  logic [PRE_W-1:0] low_val;
  logic [HI_W-1:0]  high_val;

  assign load = rst | clr;

  pscnt_prescaler #(.PRE_W(PRE_W), .INIT_LO(INIT_LO)) u_pre (
    .clk   (clk),
    .load  (load),
    .low_q (low_val),
    .adv_q (hi_adv)
  );

  pscnt_high #(.HI_W(HI_W), .INIT_HI(INIT_HI)) u_high (
    .clk  (clk),
    .load (load),
    .adv  (hi_adv),
    .hi_q (high_val)
  );

  assign count = {high_val, low_val};

  // R1 / R7: plus one every free cycle, wrapping modulo 2^CNT_W
  a_r1_plus_one: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count - $past(count)) == CNT_W'(1))
    else $error("a_r1_plus_one");

  // R5: reset loads the start value
  a_r5_reset_load: assert property (@(posedge clk)
    rst |=> count == INIT_VALUE)
    else $error("a_r5_reset_load");

  // R6: clear loads the start value
  a_r6_clear_load: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == INIT_VALUE)
    else $error("a_r6_clear_load");

  // R7: all ones goes straight to zero
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (load)
    (&count) |=> count == '0)
    else $error("a_r7_wrap_zero");

endmodule

// File: tb/prescaled_counter_bench.sv
module prescaled_counter_bench;

  localparam int          W      = 64;
  localparam logic [63:0] INIT_W = 64'hFFFF_FFFF_FFFF_FFF0;
  localparam logic [63:0] INIT_3 = 64'h0000_0000_FFFF_FFF9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic [W-1:0] cnt_a, cnt_w, cnt_3;
  logic [W-1:0] exp_a, exp_w, exp_3;
  logic [W-1:0] prev_a, prev_3;
  logic loaded_q = 1'b1;
  logic mon_en = 1'b0;
  logic done = 1'b0;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  prescaled_counter u_prescaled_counter (.clk(clk), .rst(rst), .clr(clr), .count(cnt_a));
  prescaled_counter #(.INIT_VALUE(INIT_W)) u_prescaled_counter_wrap
    (.clk(clk), .rst(rst), .clr(clr), .count(cnt_w));
  prescaled_counter #(.PRE_W(3), .INIT_VALUE(INIT_3)) u_prescaled_counter_pre3
    (.clk(clk), .rst(rst), .clr(clr), .count(cnt_3));

  // reference: load on rst/clr, otherwise plain 64-bit increment
  always @(posedge clk) begin
    exp_a    <= (rst || clr) ? 64'd0  : exp_a + 64'd1;
    exp_w    <= (rst || clr) ? INIT_W : exp_w + 64'd1;
    exp_3    <= (rst || clr) ? INIT_3 : exp_3 + 64'd1;
    loaded_q <= rst || clr;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // every-cycle comparison plus section-boundary checks
  always @(negedge clk) begin
    if (mon_en) begin
      chk("R1", cnt_a, exp_a);
      chk("R7", cnt_w, exp_w);
      chk("R8", cnt_3, exp_3);
      if (!loaded_q) begin
        // R2 R3 R4: upper 62 bits move only when low was 2'b11, and by one
        if (prev_a[1:0] == 2'b11)
          chk("R3", {2'b00, cnt_a[63:2]}, {2'b00, prev_a[63:2]} + 64'd1);
        else
          chk("R4", {2'b00, cnt_a[63:2]}, {2'b00, prev_a[63:2]});
        // R8: upper 61 bits move only when low 3 bits were 3'b111
        if (prev_3[2:0] == 3'b111)
          chk("R8", {3'b000, cnt_3[63:3]}, {3'b000, prev_3[63:3]} + 64'd1);
        else
          chk("R8", {3'b000, cnt_3[63:3]}, {3'b000, prev_3[63:3]});
      end
    end
    prev_a <= cnt_a;
    prev_3 <= cnt_3;
  end

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5", cnt_a, 64'd0);
    chk("R5", cnt_w, INIT_W);
    chk("R5", cnt_3, INIT_3);
    rst = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic t_count_and_wrap;
    @(negedge clk);
    chk("R1", cnt_a, 64'd1);
    repeat (6) @(negedge clk);
    chk("R8", cnt_3, 64'h0000_0001_0000_0000);   // carry into bit 32 after 7 steps
    repeat (9) @(negedge clk);
    chk("R7", cnt_w, 64'd0);                      // all ones -> zero after 16 steps
    chk("R2", cnt_a, 64'd16);
    @(negedge clk);
    chk("R7", cnt_w, 64'd1);
  endtask

  task automatic t_clear_on_tc;
    while (cnt_a[1:0] != 2'b11) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R6", cnt_a, 64'd0);
    chk("R6", cnt_w, INIT_W);
    repeat (3) @(negedge clk);
    chk("R6", cnt_a, 64'd3);                      // no stray high-section step
    @(negedge clk);
    chk("R6", cnt_a, 64'd4);
  endtask

  task automatic t_long_run;
    repeat (500) @(negedge clk);
    chk("R1", cnt_a, 64'd504);
  endtask

  initial begin
    t_reset();
    t_count_and_wrap();
    t_clear_on_tc();
    t_long_run();
    t_reset();
    t_count_and_wrap();
    done = 1'b1;
    mon_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule